// File: doc/BRIEF.md
# Flash command validator

This block takes the control word that software writes to start a flash operation and decides whether it may go to the flash sequencer. It decodes the operation kind (read, program, erase), the target partition and info-page selector, the program flavour (normal or repair), the erase granularity (page or bank) and the transfer length. It then aligns the start address to the granularity of the operation and checks the request against the programming-window and program-type rules. A legal request leaves as a one-cycle command pulse carrying the decoded fields and aligned address. An illegal one starts nothing and is recorded in a sticky error-code register.

While a command is outstanding the block reports busy and locks the control word. A stub completion input stands in for the flash array. That input ends the operation, and the block then pulses a done interrupt and, if the array reported a failure, an error interrupt. The lock stays on for one further cycle after every completion, so a new start is taken no earlier than one cycle after the previous one finished. The error-code bits are cleared by writing ones to them.

Top module: `fcv_top`

## Requirements
- R1: After reset: busy=0, ctrl_wen=1, cmd_valid=0, op_done=0, op_err=0, irq_done=0, irq_err=0, err_code=0.
- R2: A control write with bit 0 (start) set while ctrl_wen=1 and no check failing gives cmd_valid=1 for exactly the next cycle, with the fields copied from the word: op from bits 5:4 (0 read, 1 program, 2 erase), repair from bit 6, bank erase from bit 7, info partition from bit 8, info selector from bits 10:9, and word count minus one from bits 27:16. busy=1 from that cycle until completion.
- R3: cmd_addr is start_addr with bits 1:0 cleared for read and program, with the low 11 bits cleared (2048-byte page) for page erase, and with the low 19 bits cleared (bank of 256 pages) for bank erase.
- R4: For a program request, if the word offset within a 16-word window (start_addr bits 5:2) plus the count field exceeds 15, err_code bit 4 is set and no command is issued.
- R5: For a program request, repair (bit 6 = 1) needs ptype_en bit 1 and normal needs ptype_en bit 0. Otherwise err_code bit 5 is set and no command is issued. Erase and read ignore ptype_en.
- R6: Operation code 3 sets err_code bit 0 and issues no command.
- R7: prot_deny high with a start sets err_code bit 1 and issues no command.
- R8: ctrl_wen=0 while busy and for the single cycle after any completion. A control write in that time changes no command or state and sets err_code bit 6.
- R9: array_done while busy gives, in the next cycle, busy=0, op_done=1 and irq_done=1, with irq_done lasting one cycle. array_done while not busy has no effect.
- R10: array_err with array_done sets err_code bit 2 for a read and bit 3 for a program or erase, and also gives op_err=1 and a one-cycle irq_err.
- R11: A rejected start completes at once: in the next cycle op_done=1, op_err=1, irq_done=1 and irq_err=1 (each pulse one cycle), and busy stays 0.
- R12: err_code bits are sticky. err_clr_we clears the bits set in err_clr_mask, and a bit being set in the same cycle stays set.
- R13: An accepted start clears op_done and op_err in the cycle it issues the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| start_addr | input | ADDR_W | Byte start address of the operation |
| ptype_en | input | 2 | Program type enables: bit 0 normal, bit 1 repair |
| prot_deny | input | 1 | Protection verdict for the request being started |
| err_clr_we | input | 1 | Error-code clear strobe |
| err_clr_mask | input | 7 | Error bits to clear (write 1 to clear) |
| array_done | input | 1 | Stub completion from the flash array |
| array_err | input | 1 | Stub failure flag, valid with array_done |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_op | output | 2 | Issued operation |
| cmd_repair | output | 1 | Repair programming selected |
| cmd_bank | output | 1 | Bank erase selected |
| cmd_info_part | output | 1 | Info partition selected |
| cmd_info_sel | output | 2 | Info page selector |
| cmd_num | output | 12 | Word count minus one |
| cmd_addr | output | ADDR_W | Aligned start address |
| busy | output | 1 | Operation in progress |
| ctrl_wen | output | 1 | Control word may be written |
| op_done | output | 1 | Operation-done status |
| op_err | output | 1 | Operation-error status |
| irq_done | output | 1 | Done interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| err_code | output | 7 | Sticky error code |

## Verification
A sequencer state that is wrong shows first at ctrl_wen and busy. A stuck run state keeps ctrl_wen low, so the next start is missed and err_code bit 6 rises one cycle after the write. A skipped cool-down cycle lets a start land directly after irq_done. A wrong decode or alignment appears on cmd_addr, cmd_num or the error bits in the cycle right after the start write, because every path from the control word to the outputs passes through exactly one register. A bad sticky-bit update shows in err_code one cycle after the set or clear strobe.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
  localparam int NUM_W = 12;
  localparam int ERR_W = 7;

  // error-code bit positions (software decodes these)
  localparam int E_OP   = 0;
  localparam int E_PROT = 1;
  localparam int E_RD   = 2;
  localparam int E_PROG = 3;
  localparam int E_WIN  = 4;
  localparam int E_TYPE = 5;
  localparam int E_UPD  = 6;

  // control word field positions
  localparam int CW_START    = 0;
  localparam int CW_OP_LSB   = 4;
  localparam int CW_REPAIR   = 6;
  localparam int CW_BANK     = 7;
  localparam int CW_PART     = 8;
  localparam int CW_INFO_LSB = 9;
  localparam int CW_NUM_LSB  = 16;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } fcv_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_COOL = 2'd2
  } fcv_state_e;

  typedef struct packed {
    fcv_op_e          op;
    logic             repair;
    logic             bank;
    logic             info_part;
    logic [1:0]       info_sel;
    logic [NUM_W-1:0] num;
  } fcv_req_t;
endpackage

// File: rtl/fcv_decode.sv
module fcv_decode
  import fcv_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PAGE_LSB = 11,
  parameter int BANK_LSB = 19,
  parameter int WIN_LSB  = 4
) (
  input  logic [31:0]       ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ptype_en,
  input  logic              prot_deny,
  output fcv_req_t          req,
  output logic [ADDR_W-1:0] addr_al,
  output logic [ERR_W-1:0]  err
);
  localparam int SPAN_W  = NUM_W + 1;
  localparam int WIN_MAX = (1 << WIN_LSB) - 1;
  localparam logic [ADDR_W-1:0] WORD_KEEP = ~((ADDR_W'(1) << 2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PAGE_KEEP = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BANK_KEEP = ~((ADDR_W'(1) << BANK_LSB) - ADDR_W'(1));

  logic [WIN_LSB-1:0] win_ofs;
  logic [SPAN_W-1:0]  span;
  logic               win_cross;
  logic               type_off;
  logic               ctrl_unused;

  assign ctrl_unused = ^{ctrl[3:0], ctrl[15:11], ctrl[31:28]};

  always_comb begin
    req.op        = fcv_op_e'(ctrl[CW_OP_LSB +: 2]);
    req.repair    = ctrl[CW_REPAIR];
    req.bank      = ctrl[CW_BANK];
    req.info_part = ctrl[CW_PART];
    req.info_sel  = ctrl[CW_INFO_LSB +: 2];
    req.num       = ctrl[CW_NUM_LSB +: NUM_W];
  end

  assign win_ofs   = addr[WIN_LSB+1:2];
  assign span      = SPAN_W'(win_ofs) + SPAN_W'(req.num);
  assign win_cross = span > SPAN_W'(WIN_MAX);
  assign type_off  = req.repair ? ~ptype_en[1] : ~ptype_en[0];

  always_comb begin
    case (req.op)
      OP_ERASE: addr_al = addr & (req.bank ? BANK_KEEP : PAGE_KEEP);
      default:  addr_al = addr & WORD_KEEP;
    endcase
  end

  always_comb begin
    err         = '0;
    err[E_OP]   = (req.op == OP_BAD);
    err[E_PROT] = prot_deny;
    if (req.op == OP_PROG) begin
      err[E_WIN]  = win_cross;
      err[E_TYPE] = type_off;
    end
  end
endmodule

// File: rtl/fcv_errreg.sv
module fcv_errreg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        q[g] <= 1'b0;
      else if (set[g])                q[g] <= 1'b1;
      else if (clr_we && clr_mask[g]) q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fcv_seq.sv
module fcv_seq
  import fcv_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              rej,
  input  fcv_req_t          req,
  input  logic [ADDR_W-1:0] addr_al,
  input  logic              array_done,
  input  logic              array_err,
  output logic              cmd_valid,
  output fcv_req_t          cmd_q,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              ctrl_wen,
  output logic              op_done,
  output logic              op_err,
  output logic              irq_done,
  output logic              irq_err,
  output logic [ERR_W-1:0]  fail_set
);
  fcv_state_e state;
  logic       fin;

  assign fin      = (state == S_RUN) && array_done;
  assign busy     = (state == S_RUN);
  assign ctrl_wen = (state == S_IDLE);

  always_comb begin
    fail_set = '0;
    if (fin && array_err) begin
      if (cmd_q.op == OP_READ) fail_set[E_RD]   = 1'b1;
      else                     fail_set[E_PROG] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cmd_valid <= 1'b0;
      cmd_q     <= '0;
      cmd_addr  <= '0;
      op_done   <= 1'b0;
      op_err    <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take) begin
            if (rej) begin
              state    <= S_COOL;
              op_done  <= 1'b1;
              op_err   <= 1'b1;
              irq_done <= 1'b1;
              irq_err  <= 1'b1;
            end else begin
              state     <= S_RUN;
              cmd_valid <= 1'b1;
              cmd_q     <= req;
              cmd_addr  <= addr_al;
              op_done   <= 1'b0;
              op_err    <= 1'b0;
            end
          end
        end
        S_RUN: begin
          if (array_done) begin
            state    <= S_COOL;
            op_done  <= 1'b1;
            irq_done <= 1'b1;
            if (array_err) begin
              op_err  <= 1'b1;
              irq_err <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcv_top.sv
module fcv_top
  import fcv_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int PAGE_BYTES     = 2048,
  parameter int PAGES_PER_BANK = 256,
  parameter int WIN_WORDS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        ptype_en,
  input  logic              prot_deny,
  input  logic              err_clr_we,
  input  logic [ERR_W-1:0]  err_clr_mask,
  input  logic              array_done,
  input  logic              array_err,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic              cmd_repair,
  output logic              cmd_bank,
  output logic              cmd_info_part,
  output logic [1:0]        cmd_info_sel,
  output logic [NUM_W-1:0]  cmd_num,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              ctrl_wen,
  output logic              op_done,
  output logic              op_err,
  output logic              irq_done,
  output logic              irq_err,
  output logic [ERR_W-1:0]  err_code
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int BANK_LSB = $clog2(PAGE_BYTES * PAGES_PER_BANK);
  localparam int WIN_LSB  = $clog2(WIN_WORDS);

  fcv_req_t          dec_req;
  fcv_req_t          cmd_q;
  logic [ADDR_W-1:0] dec_addr;
  logic [ERR_W-1:0]  dec_err;
  logic [ERR_W-1:0]  fail_set;
  logic [ERR_W-1:0]  err_set;
  logic              take;
  logic              upd_hit;

  fcv_decode #(
    .ADDR_W  (ADDR_W),
    .PAGE_LSB(PAGE_LSB),
    .BANK_LSB(BANK_LSB),
    .WIN_LSB (WIN_LSB)
  ) dec_i (
    .ctrl     (ctrl_wdata),
    .addr     (start_addr),
    .ptype_en (ptype_en),
    .prot_deny(prot_deny),
    .req      (dec_req),
    .addr_al  (dec_addr),
    .err      (dec_err)
  );

  assign take    = ctrl_we && ctrl_wdata[CW_START] && ctrl_wen;
  assign upd_hit = ctrl_we && !ctrl_wen;

  fcv_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .rej       (|dec_err),
    .req       (dec_req),
    .addr_al   (dec_addr),
    .array_done(array_done),
    .array_err (array_err),
    .cmd_valid (cmd_valid),
    .cmd_q     (cmd_q),
    .cmd_addr  (cmd_addr),
    .busy      (busy),
    .ctrl_wen  (ctrl_wen),
    .op_done   (op_done),
    .op_err    (op_err),
    .irq_done  (irq_done),
    .irq_err   (irq_err),
    .fail_set  (fail_set)
  );

  always_comb begin
    err_set        = fail_set | (take ? dec_err : '0);
    err_set[E_UPD] = err_set[E_UPD] | upd_hit;
  end

  fcv_errreg #(.W(ERR_W)) err_i (
    .clk     (clk),
    .rst     (rst),
    .set     (err_set),
    .clr_we  (err_clr_we),
    .clr_mask(err_clr_mask),
    .q       (err_code)
  );

  assign cmd_op        = cmd_q.op;
  assign cmd_repair    = cmd_q.repair;
  assign cmd_bank      = cmd_q.bank;
  assign cmd_info_part = cmd_q.info_part;
  assign cmd_info_sel  = cmd_q.info_sel;
  assign cmd_num       = cmd_q.num;
endmodule

// File: rtl/fcv_chk.sv
module fcv_chk #(
  parameter int ADDR_W   = 20,
  parameter int PAGE_LSB = 11,
  parameter int WIN_LSB  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_we,
  input logic              err_clr_we,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              cmd_bank,
  input logic [11:0]       cmd_num,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              busy,
  input logic              ctrl_wen,
  input logic              op_err,
  input logic              irq_done,
  input logic              irq_err,
  input logic [6:0]        err_code
);
  logic [12:0] span_chk;
  assign span_chk = 13'(cmd_addr[WIN_LSB+1:2]) + 13'(cmd_num);

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);                                          // R2
  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);                                                // R2
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != 2'd2) |-> (cmd_addr[1:0] == 2'b00));        // R3
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && !cmd_bank) |-> (cmd_addr[PAGE_LSB-1:0] == '0)); // R3
  AST_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |-> (span_chk < 13'(1 << WIN_LSB)));  // R4
  AST_NO_BAD_OP: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != 2'd3));                                    // R6
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(ctrl_we) && $past(ctrl_wen)));                 // R8
  AST_LOCK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctrl_wen);                                                // R8
  AST_LOCK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> !ctrl_wen);                                            // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);                                            // R9
  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> op_err);                                                // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(err_clr_we) |-> ((err_code & $past(err_code)) == $past(err_code))); // R12
endmodule

bind fcv_top fcv_chk #(
  .ADDR_W  (ADDR_W),
  .PAGE_LSB(PAGE_LSB),
  .WIN_LSB (WIN_LSB)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctrl_we   (ctrl_we),
  .err_clr_we(err_clr_we),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .cmd_num   (cmd_num),
  .cmd_addr  (cmd_addr),
  .busy      (busy),
  .ctrl_wen  (ctrl_wen),
  .op_err    (op_err),
  .irq_done  (irq_done),
  .irq_err   (irq_err),
  .err_code  (err_code)
);

// File: tb/fcv_top_tb_top.sv
`timescale 1ns/1ps
module fcv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [19:0] start_addr = '0;
  logic [1:0]  ptype_en = '0;
  logic        prot_deny = 1'b0;
  logic        err_clr_we = 1'b0;
  logic [6:0]  err_clr_mask = '0;
  logic        array_done = 1'b0;
  logic        array_err = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_repair, cmd_bank, cmd_info_part;
  logic [1:0]  cmd_info_sel;
  logic [11:0] cmd_num;
  logic [19:0] cmd_addr;
  logic        busy, ctrl_wen, op_done, op_err, irq_done, irq_err;
  logic [6:0]  err_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fcv_top dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .start_addr(start_addr), .ptype_en(ptype_en), .prot_deny(prot_deny),
    .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
    .array_done(array_done), .array_err(array_err),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_repair(cmd_repair),
    .cmd_bank(cmd_bank), .cmd_info_part(cmd_info_part),
    .cmd_info_sel(cmd_info_sel), .cmd_num(cmd_num), .cmd_addr(cmd_addr),
    .busy(busy), .ctrl_wen(ctrl_wen), .op_done(op_done), .op_err(op_err),
    .irq_done(irq_done), .irq_err(irq_err), .err_code(err_code)
  );

  // {ctrl, addr, ptype_en, prot_deny, exp_valid, exp_addr, exp_err}
  localparam int NV = 15;
  localparam logic [82:0] VEC [NV] = '{
    {32'h00050001, 20'h12347, 2'b11, 1'b0, 1'b1, 20'h12344, 7'h00},
    {32'h000D0011, 20'h00108, 2'b01, 1'b0, 1'b1, 20'h00108, 7'h00},
    {32'h000E0011, 20'h00108, 2'b01, 1'b0, 1'b0, 20'h00000, 7'h10},
    {32'h00000051, 20'h00200, 2'b01, 1'b0, 1'b0, 20'h00000, 7'h20},
    {32'h00000051, 20'h00203, 2'b11, 1'b0, 1'b1, 20'h00200, 7'h00},
    {32'h00000011, 20'h00200, 2'b10, 1'b0, 1'b0, 20'h00000, 7'h20},
    {32'h000F0011, 20'h00010, 2'b00, 1'b0, 1'b0, 20'h00000, 7'h30},
    {32'h00000021, 20'h5ABCD, 2'b00, 1'b0, 1'b1, 20'h5A800, 7'h00},
    {32'h000000A1, 20'hDABCD, 2'b00, 1'b0, 1'b1, 20'h80000, 7'h00},
    {32'h00000031, 20'h00100, 2'b11, 1'b0, 1'b0, 20'h00000, 7'h01},
    {32'h00000001, 20'h00100, 2'b11, 1'b1, 1'b0, 20'h00000, 7'h02},
    {32'h00000501, 20'h00FFF, 2'b11, 1'b0, 1'b1, 20'h00FFC, 7'h00},
    {32'h00000011, 20'h0003C, 2'b01, 1'b0, 1'b1, 20'h0003C, 7'h00},
    {32'h0FFF0011, 20'h00000, 2'b11, 1'b0, 1'b0, 20'h00000, 7'h10},
    {32'h0FFF0001, 20'h00006, 2'b00, 1'b0, 1'b1, 20'h00004, 7'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] c, input logic [19:0] a,
                    input logic [1:0] pt, input logic pd);
    ctrl_we = 1'b1; ctrl_wdata = c; start_addr = a; ptype_en = pt; prot_deny = pd;
    @(negedge clk);
    ctrl_we = 1'b0; prot_deny = 1'b0;
  endtask

  task automatic fin(input logic e);
    array_done = 1'b1; array_err = e;
    @(negedge clk);
    array_done = 1'b0; array_err = 1'b0;
  endtask

  task automatic clr(input logic [6:0] m);
    err_clr_we = 1'b1; err_clr_mask = m;
    @(negedge clk);
    err_clr_we = 1'b0; err_clr_mask = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ctrl_wen", ctrl_wen, 1);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 err_code", err_code, 0);
    chk("R1 irqs", {irq_done, irq_err, op_done, op_err}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c; logic [19:0] a; logic [1:0] pt; logic pd;
      logic ev; logic [19:0] ea; logic [6:0] ee;
      {c, a, pt, pd, ev, ea, ee} = VEC[i];
      wr(c, a, pt, pd);
      chk("R2/R4/R5/R6/R7 cmd_valid", cmd_valid, ev);
      chk("R4/R5/R6/R7 err_code", err_code, ee);
      if (ev) begin
        chk("R3 cmd_addr", cmd_addr, ea);
        chk("R2 cmd fields",
            {cmd_num, cmd_info_sel, cmd_info_part, cmd_bank, cmd_repair, cmd_op},
            {c[27:16], c[10:9], c[8], c[7], c[6], c[5:4]});
        chk("R2 busy", busy, 1);
        fin(1'b0);
        chk("R9 irq_done", irq_done, 1);
        chk("R8 ctrl_wen after done", ctrl_wen, 0);
      end else begin
        chk("R11 reject flags", {busy, irq_done, irq_err, op_done, op_err}, 5'b01111);
      end
      @(negedge clk);
      clr(7'h7F);
    end

    // R8 write while busy and during cool-down
    wr(32'h00000001, 20'h00100, 2'b11, 1'b0);
    chk("R2 accept", busy, 1);
    wr(32'h00000011, 20'h00000, 2'b11, 1'b0);
    chk("R8 ignored while busy", {cmd_valid, busy}, 2'b01);
    chk("R8 update error", err_code, 7'h40);
    fin(1'b0);
    chk("R9 done flags", {busy, op_done, op_err, irq_done}, 4'b0101);
    wr(32'h00000001, 20'h00100, 2'b11, 1'b0);
    chk("R8 ignored in cool cycle", {cmd_valid, busy, ctrl_wen}, 3'b001);
    chk("R9 irq_done one cycle", irq_done, 0);
    clr(7'h7F);
    chk("R12 clear all", err_code, 0);

    // R9 done while idle
    fin(1'b1);
    chk("R9 idle done ignored", {irq_done, irq_err, err_code}, 9'h0);

    // R10 array failures
    wr(32'h00000001, 20'h00100, 2'b11, 1'b0);
    fin(1'b1);
    chk("R10 read failure", {err_code, irq_err, op_err}, {7'h04, 2'b11});
    @(negedge clk);
    clr(7'h7F);
    wr(32'h00000011, 20'h00000, 2'b01, 1'b0);
    chk("R13 status cleared", {cmd_valid, op_done, op_err}, 3'b100);
    fin(1'b1);
    chk("R10 program failure", err_code, 7'h08);
    @(negedge clk);
    clr(7'h7F);

    // R11 / R12
    wr(32'h00000031, 20'h00000, 2'b11, 1'b0);
    chk("R6 bad op", err_code, 7'h01);
    @(negedge clk);
    chk("R11 irq_err one cycle", {irq_err, irq_done}, 2'b00);
    ctrl_we = 1'b1; ctrl_wdata = 32'h00000031; err_clr_we = 1'b1; err_clr_mask = 7'h01;
    @(negedge clk);
    ctrl_we = 1'b0; err_clr_we = 1'b0; err_clr_mask = '0;
    chk("R12 set wins over clear", err_code, 7'h01);
    @(negedge clk);
    clr(7'h01);
    chk("R12 masked clear", err_code, 7'h00);
    wr(32'h000F0011, 20'h00010, 2'b00, 1'b0);
    @(negedge clk);
    clr(7'h10);
    chk("R12 partial clear", err_code, 7'h20);
    clr(7'h7F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule